// File: doc/BRIEF.md
# Interrupt Status Aggregation Controller

The controller gathers single-cycle event pulses into two sticky status registers. One register holds the standard event sources. The other holds the vendor sources. Each status register has its own mask register, and a mask bit of 1 blocks the matching source. The unmasked bits of both registers are ORed into a single extended-status flag. That flag is also brought out as a port, so that the footer logic can carry it.

An active-low interrupt line is driven from three conditions: receive data available, transmit space available, and the extended-status flag. A footer-snapshot strobe records all three conditions as already reported. The interrupt then stays quiet until one of the conditions becomes true without having been reported. That happens when a condition that was clear rises, or when a reported condition drops and later rises again.

After an interrupt, the host reads the footer first. It reads the status registers only when the extended flag is set, and it clears the bits it has handled by writing ones to them.

Top module: `irq_agg_ctrl`

## Requirements
- R1: While reset is held and after it is released, both status registers read 0, both mask registers read all ones, `ext_stat` is 0 and `irq_n` is 1.
- R2: An event pulse on a status input sets the matching status bit at the next clock edge. The bit is visible on `reg_rdata` right after that edge.
- R3: A status bit stays set until the host writes 1 to it. A write of 0 to a set bit leaves it set.
- R4: When an event pulse and a host write of 1 hit the same status bit in the same cycle, the bit ends set.
- R5: `ext_stat` is 1 exactly when at least one status bit in either register has its mask bit at 0. Setting a mask bit to 1 hides that source from `ext_stat` and from the interrupt.
- R6: A rise of `rx_avail` or `tx_avail` that no footer has reported drives `irq_n` low right after the next clock edge.
- R7: An unreported rise of `ext_stat` drives `irq_n` low one clock edge after `ext_stat` changes.
- R8: A `footer_snap` pulse marks the present three conditions as reported. `irq_n` is 1 after that edge and stays 1 while the conditions do not newly rise.
- R9: A reported condition that drops loses its reported mark, so its next rise asserts the interrupt again.
- R10: Register addresses are: 0 standard status, 1 standard mask, 2 vendor status, 3 vendor mask. The vendor bit positions are: 0 sync event, 1–3 timestamp missed A/B/C, 4–6 timestamp overflow A/B/C, 7 undervoltage, 8 ECC error, 9 bus error, 10 state-machine fault, 11 transmit fatal, 12 receive fatal. Unused upper read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| std_evt | input | STD_W | Standard event pulses, one per status bit |
| vnd_evt | input | 13 | Vendor event pulses, laid out as in R10 |
| rx_avail | input | 1 | Receive data is available |
| tx_avail | input | 1 | Transmit buffer space is available |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data; for status registers, the ones mark bits to clear |
| reg_rdata | output | DATA_W | Combinational read data of the addressed register |
| footer_snap | input | 1 | Pulse when a footer is captured for delivery |
| ext_stat | output | 1 | Extended-status flag |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The timing checks use these latencies. A status bit, a mask change and the read data of the addressed register appear right after the edge that takes the pulse or the write. `ext_stat` follows on the same edge. Because `irq_n` is registered from the conditions seen at an edge, it reacts one edge after `rx_avail` or `tx_avail` changes, one edge after a snapshot, and two edges after an event pulse that raises `ext_stat`. The stimulus changes just after the falling edge. Each expectation is queued for the values after the next rising edge and compared at the falling edge that follows, so every check samples in the cycle its result is due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int VND_W = 13;

    // vendor status bit positions
    localparam int VB_SYNC     = 0;
    localparam int VB_MISS_A   = 1;
    localparam int VB_OVF_A    = 4;
    localparam int VB_UV       = 7;
    localparam int VB_ECC      = 8;
    localparam int VB_BUS      = 9;
    localparam int VB_FSM      = 10;
    localparam int VB_TX_FATAL = 11;
    localparam int VB_RX_FATAL = 12;

    typedef enum logic [1:0] {
        A_STD_STAT = 2'd0,
        A_STD_MASK = 2'd1,
        A_VND_STAT = 2'd2,
        A_VND_MASK = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic rx;
        logic tx;
        logic ext;
    } cond_t;

    function automatic cond_t keep_reported(cond_t rep, cond_t now);
        return cond_t'(rep & now);
    endfunction

    function automatic logic any_fresh(cond_t now, cond_t rep);
        return |(now & ~rep);
    endfunction

endpackage

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat
);

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr_vec) | set_vec;
    end

    assert_set_on_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((stat & $past(set_vec)) == $past(set_vec)));

    assert_hold_without_clear_R3: assert property (@(posedge clk) disable iff (rst)
        !(|clr_vec) |=> ((stat & $past(stat)) == $past(stat)));

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & clr_vec)) |=>
            ((stat & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst)       mask <= '1;
        else if (load) mask <= din;
    end

    assert_mask_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (mask == '1));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mask));

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
    import irq_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cond_t cond,
    input  logic  snap,
    output logic  irq_n
);

    cond_t rep_q;
    cond_t rep_d;

    always_comb begin
        if (snap) rep_d = cond;
        else      rep_d = keep_reported(rep_q, cond);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_q <= '0;
            irq_n <= 1'b1;
        end else begin
            rep_q <= rep_d;
            irq_n <= ~any_fresh(cond, rep_d);
        end
    end

    assert_quiet_after_snap_R8: assert property (@(posedge clk) disable iff (rst)
        snap |=> irq_n);

    assert_rx_raises_R6: assert property (@(posedge clk) disable iff (rst)
        (cond.rx && !rep_q.rx && !snap) |=> !irq_n);

    assert_ext_raises_R7: assert property (@(posedge clk) disable iff (rst)
        (cond.ext && !rep_q.ext && !snap) |=> !irq_n);

    assert_drop_unmarks_R9: assert property (@(posedge clk) disable iff (rst)
        (!cond.tx && !snap) |=> !rep_q.tx);

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int STD_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STD_W-1:0]  std_evt,
    input  logic [VND_W-1:0]  vnd_evt,
    input  logic              rx_avail,
    input  logic              tx_avail,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              footer_snap,
    output logic              ext_stat,
    output logic              irq_n
);

    logic [STD_W-1:0] std_stat, std_mask, std_clr;
    logic [VND_W-1:0] vnd_stat, vnd_mask, vnd_clr;
    logic             std_mask_ld, vnd_mask_ld;
    reg_addr_e        sel;
    cond_t            cond;

    assign sel = reg_addr_e'(reg_addr);

    assign std_clr     = (reg_wr && sel == A_STD_STAT) ? reg_wdata[STD_W-1:0] : '0;
    assign vnd_clr     = (reg_wr && sel == A_VND_STAT) ? reg_wdata[VND_W-1:0] : '0;
    assign std_mask_ld = reg_wr && sel == A_STD_MASK;
    assign vnd_mask_ld = reg_wr && sel == A_VND_MASK;

    irq_sticky_reg #(.W(STD_W)) u_std_stat (
        .clk(clk), .rst(rst), .set_vec(std_evt), .clr_vec(std_clr), .stat(std_stat));

    irq_sticky_reg #(.W(VND_W)) u_vnd_stat (
        .clk(clk), .rst(rst), .set_vec(vnd_evt), .clr_vec(vnd_clr), .stat(vnd_stat));

    irq_mask_reg #(.W(STD_W)) u_std_mask (
        .clk(clk), .rst(rst), .load(std_mask_ld), .din(reg_wdata[STD_W-1:0]),
        .mask(std_mask));

    irq_mask_reg #(.W(VND_W)) u_vnd_mask (
        .clk(clk), .rst(rst), .load(vnd_mask_ld), .din(reg_wdata[VND_W-1:0]),
        .mask(vnd_mask));

    assign ext_stat = (|(std_stat & ~std_mask)) | (|(vnd_stat & ~vnd_mask));

    always_comb begin
        case (sel)
            A_STD_STAT: reg_rdata = DATA_W'(std_stat);
            A_STD_MASK: reg_rdata = DATA_W'(std_mask);
            A_VND_STAT: reg_rdata = DATA_W'(vnd_stat);
            default:    reg_rdata = DATA_W'(vnd_mask);
        endcase
    end

    assign cond = '{rx: rx_avail, tx: tx_avail, ext: ext_stat};

    irq_line_gen u_irq (
        .clk(clk), .rst(rst), .cond(cond), .snap(footer_snap), .irq_n(irq_n));

    assert_irq_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> irq_n);

    assert_full_mask_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        ((&std_mask) && (&vnd_mask)) |-> !ext_stat);

endmodule

// File: tb/irq_agg_ctrl_tb.sv
module irq_agg_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int STD_W  = 8;
    localparam int DATA_W = 16;
    localparam int VND_W  = 13;

    typedef enum logic [1:0] {K_RD, K_IRQ, K_EXT} kind_e;
    typedef struct {
        kind_e       kind;
        logic [15:0] exp;
        string       tag;
    } chk_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [STD_W-1:0]  std_evt = '0;
    logic [VND_W-1:0]  vnd_evt = '0;
    logic              rx_avail = 1'b0, tx_avail = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              footer_snap = 1'b0;
    logic              ext_stat, irq_n;

    int   n_chk = 0, n_fail = 0;
    bit   done = 0;
    chk_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_ctrl #(.STD_W(STD_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .std_evt(std_evt), .vnd_evt(vnd_evt),
        .rx_avail(rx_avail), .tx_avail(tx_avail), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .footer_snap(footer_snap), .ext_stat(ext_stat), .irq_n(irq_n));

    // monitor: compares everything queued during the previous cycle
    initial forever begin
        @(negedge clk);
        while (sb.size() > 0) begin
            chk_t c;
            logic [15:0] act;
            c = sb.pop_front();
            case (c.kind)
                K_RD:    act = reg_rdata;
                K_IRQ:   act = {15'd0, irq_n};
                default: act = {15'd0, ext_stat};
            endcase
            n_chk++;
            if (act !== c.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", c.tag, act, c.exp);
            end
        end
    end

    task automatic expect_v(kind_e k, logic [15:0] v, string tag);
        chk_t c;
        c.kind = k; c.exp = v; c.tag = tag;
        sb.push_back(c);
    endtask

    task automatic tick();
        @(negedge clk); #1;
        std_evt = '0; vnd_evt = '0; reg_wr = 1'b0; footer_snap = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        repeat (3) tick();
        // R1: values under reset and after release
        reg_addr = 2'd0; expect_v(K_RD, 16'h0000, "R1 std status"); tick();
        rst = 1'b0;
        expect_v(K_IRQ, 16'h1, "R1 irq_n idle"); expect_v(K_EXT, 16'h0, "R1 ext");
        reg_addr = 2'd1; expect_v(K_RD, 16'h00FF, "R1 std mask"); tick();
        reg_addr = 2'd3; expect_v(K_RD, 16'h1FFF, "R1 vnd mask"); tick();
        reg_addr = 2'd2; expect_v(K_RD, 16'h0000, "R1 vnd status"); tick();

        // R2 / R10: ECC pulse sets vendor bit 8; masked so no ext (R5)
        vnd_evt[8] = 1'b1;
        expect_v(K_RD, 16'h0100, "R2 R10 ecc bit"); expect_v(K_EXT, 16'h0, "R5 masked");
        tick();
        expect_v(K_IRQ, 16'h1, "R5 masked irq"); tick();

        // R3: write 0 at bit 8 keeps it, write 1 clears it
        wr(2'd2, 16'h00FF); expect_v(K_RD, 16'h0100, "R3 zero write"); tick();
        wr(2'd2, 16'h0100); expect_v(K_RD, 16'h0000, "R3 one clears"); tick();

        // R4: set and clear of std bit 3 in one cycle
        std_evt[3] = 1'b1; wr(2'd0, 16'h0008);
        expect_v(K_RD, 16'h0008, "R4 set wins"); tick();

        // R5 / R7: unmask std bit 3
        wr(2'd1, 16'h00F7);
        expect_v(K_EXT, 16'h1, "R5 unmasked ext"); expect_v(K_IRQ, 16'h1, "R7 not yet");
        expect_v(K_RD, 16'h00F7, "R10 std mask read"); tick();
        expect_v(K_IRQ, 16'h0, "R7 ext irq"); tick();

        // R8: snapshot quiets the line
        footer_snap = 1'b1; expect_v(K_IRQ, 16'h1, "R8 snap"); tick();
        expect_v(K_IRQ, 16'h1, "R8 stays quiet"); tick();
        expect_v(K_IRQ, 16'h1, "R8 stays quiet 2"); tick();

        // R6: rx and tx availability
        rx_avail = 1'b1; expect_v(K_IRQ, 16'h0, "R6 rx"); tick();
        footer_snap = 1'b1; expect_v(K_IRQ, 16'h1, "R8 rx snap"); tick();
        tx_avail = 1'b1; expect_v(K_IRQ, 16'h0, "R6 tx"); tick();
        footer_snap = 1'b1; expect_v(K_IRQ, 16'h1, "R8 tx snap"); tick();

        // R9: drop and rise of rx
        rx_avail = 1'b0; expect_v(K_IRQ, 16'h1, "R9 drop quiet"); tick();
        rx_avail = 1'b1; expect_v(K_IRQ, 16'h0, "R9 rerise"); tick();
        footer_snap = 1'b1; expect_v(K_IRQ, 16'h1, "R8 snap again"); tick();

        // R9 for ext: clear, then event again
        wr(2'd0, 16'h0008);
        expect_v(K_EXT, 16'h0, "R3 ext cleared"); expect_v(K_IRQ, 16'h1, "R9 ext drop"); tick();
        std_evt[3] = 1'b1;
        expect_v(K_EXT, 16'h1, "R2 ext back"); expect_v(K_IRQ, 16'h1, "R7 one later"); tick();
        expect_v(K_IRQ, 16'h0, "R9 ext rerise"); tick();
        footer_snap = 1'b1; expect_v(K_IRQ, 16'h1, "R8 ext snap"); tick();

        // R5 vendor path: receive-fatal bit 12
        wr(2'd0, 16'h0008); expect_v(K_EXT, 16'h0, "R5 std cleared"); tick();
        wr(2'd3, 16'h0FFF); expect_v(K_EXT, 16'h0, "R5 no vnd bit"); tick();
        reg_addr = 2'd2; vnd_evt[12] = 1'b1;
        expect_v(K_RD, 16'h1000, "R10 rx fatal bit"); expect_v(K_EXT, 16'h1, "R5 vnd ext");
        tick();
        expect_v(K_IRQ, 16'h0, "R7 vnd irq"); tick();
        footer_snap = 1'b1; expect_v(K_IRQ, 16'h1, "R8 vnd snap"); tick();
        wr(2'd3, 16'h1FFF); expect_v(K_EXT, 16'h0, "R5 remask"); tick();
        expect_v(K_IRQ, 16'h1, "R5 remask irq"); tick();

        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule